// File: doc/BRIEF.md
# Voltage Monitor Event Controller

This block turns a single digital level from a supply comparator (1 when the supply is at or above a detection threshold) into three results: a sticky detection flag, an interrupt request, or a fixed-length internal reset pulse. The comparator level is first brought into the clock domain by a synchroniser chain. A crossing is then recognised in one of two ways. With the glitch filter on, the level must stay at a new value for four consecutive sampling strobes, and a change in either direction counts. With the filter off, edges are taken straight from the synchronised level, and a direction control selects rising or falling edges.

Software controls the block through a two-word register interface. One word holds the control bits. The other returns the flag and the current synchronised level. An output-mode control decides whether a recognised crossing raises an interrupt request or starts a reset pulse. Software clears the flag by writing to it. The interrupt request is cleared when the interrupt is acknowledged.

Top module: `vmon_event_ctrl`

## Requirements
- R1: A crossing is recognised only while both control bit 0 (circuit enable) and control bit 1 (monitor enable) are 1. Otherwise the flag, the interrupt request and the reset pulse are left untouched.
- R2: With control bit 2 (filter bypass) at 0, a new level is accepted only after 4 consecutive sampling strobes see it. A run of fewer equal samples followed by a different sample restarts the count and produces no crossing.
- R3: With the filter bypassed, a comparator change applied before clock edge 1 is recognised at edge 3, so the outputs show it after that edge and not before.
- R4: With the filter bypassed, control bit 3 at 0 selects rising edges only and control bit 3 at 1 selects falling edges only.
- R5: With the filter active, a change in either direction is recognised, whatever the value of control bit 3.
- R6: With control bit 4 at 0, a crossing raises irq_req. irq_req stays high until irq_ack is 1 at a clock edge. A crossing at the same edge as an acknowledge leaves irq_req high.
- R7: With control bit 4 at 1, a crossing drives rst_req high for exactly 8 clocks and does not raise irq_req. The control word keeps its value through the pulse.
- R8: Bit 0 of the status word (address 1) is the flag. Every recognised crossing sets it. Writing 0 to bit 0 clears it, and writing 1 has no effect. A crossing at the same edge as a clearing write leaves it set.
- R9: Bit 1 of the status word reads back the comparator level as seen after the 2-stage synchroniser.
- R10: After reset, irq_req and rst_req are 0, the control word is 0 and the flag is 0.
- R11: The control word sits at address 0, in bits 4:0. Each read returns, one clock after the address is presented, the register contents from before that edge, with unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Filter sampling strobe, one clock wide |
| cmp_hi | input | 1 | Asynchronous comparator level, 1 = at or above threshold |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address (0 control, 1 status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Pending interrupt request |
| rst_req | output | 1 | Internal reset pulse |

## Verification
The hardest cases to reach are the two same-edge conflicts: a clearing write or an acknowledge landing on exactly the edge where a crossing is recognised. The bench reaches them in bypass mode, where the recognition edge is a fixed three clocks after the comparator input changes. It places the status write and the acknowledge on that edge. Filter restarts are provoked by holding the comparator at a new level for fewer strobes than the filter needs, with the strobe generator running at one pulse in four clocks. A behavioural model steps alongside the design and is compared on every clock.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  // Control word layout, LSB first: det_en, mon_en, filt_off, dir_fall, mode_rst
  typedef struct packed {
    logic mode_rst;
    logic dir_fall;
    logic filt_off;
    logic mon_en;
    logic det_en;
  } vmon_ctrl_t;

  localparam int CTRL_W = $bits(vmon_ctrl_t);

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_LVL_BIT  = 1;

endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/vmon_filter.sv
module vmon_filter #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic lvl_in,
  output logic filt_chg,
  output logic raw_rise,
  output logic raw_fall
);

  localparam int CNT_W = $clog2(FILT_N + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_N - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FILT_N);

  logic             last_q;
  logic [CNT_W-1:0] run_q;
  logic             stable_q;
  logic             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= 1'b0;
      run_q    <= '0;
      stable_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      prev_q <= lvl_in;
      if (samp_en) begin
        if (lvl_in != last_q) begin
          last_q <= lvl_in;
          run_q  <= CNT_W'(1);
        end else if (run_q < CNT_FULL) begin
          run_q <= run_q + CNT_W'(1);
          if (run_q == CNT_LAST) stable_q <= lvl_in;
        end
      end
    end
  end

  assign filt_chg = samp_en && (lvl_in == last_q) && (run_q == CNT_LAST)
                    && (lvl_in != stable_q);
  assign raw_rise = lvl_in & ~prev_q;
  assign raw_fall = ~lvl_in & prev_q;

  // R2: accepted level moves only on the strobe that completes a run
  a_r2_full_run: assert property (@(posedge clk) disable iff (rst)
    (stable_q != $past(stable_q)) |-> ($past(samp_en) && $past(run_q) == CNT_LAST));

endmodule

// File: rtl/vmon_regs.sv
module vmon_regs
  import vmon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              lvl,
  input  logic              evt,
  output vmon_ctrl_t        ctrl,
  output logic              flag
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  vmon_ctrl_t        ctrl_q;
  logic              flag_q;
  logic [DATA_W-1:0] rdata_q;
  logic              flag_clr;
  logic              wdata_unused;

  assign wdata_unused = ^wdata[DATA_W-1:CTRL_W];
  assign flag_clr = we && (addr == A_STAT) && !wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we && addr == A_CTRL) begin
      ctrl_q <= vmon_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (evt)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (addr == A_CTRL) begin
        rdata_q[CTRL_W-1:0] <= ctrl_q;
      end else if (addr == A_STAT) begin
        rdata_q[STAT_FLAG_BIT] <= flag_q;
        rdata_q[STAT_LVL_BIT]  <= lvl;
      end
    end
  end

  assign ctrl  = ctrl_q;
  assign flag  = flag_q;
  assign rdata = rdata_q;

  // R8: flag drops only after a clearing write to the status word
  a_r8_fall_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(we && addr == A_STAT && !wdata[STAT_FLAG_BIT]));
  // R8: a crossing always leaves the flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q);

endmodule

// File: rtl/vmon_out.sv
module vmon_out #(
  parameter int RST_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_irq,
  input  logic evt_rst,
  input  logic irq_ack,
  output logic irq_req,
  output logic rst_req
);

  localparam int RCNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
  localparam logic [RCNT_W-1:0] RCNT_LOAD = RCNT_W'(RST_CYC - 1);

  logic              irq_q;
  logic              rst_q;
  logic [RCNT_W-1:0] rcnt_q;

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (evt_irq) irq_q <= 1'b1;
    else if (irq_ack) irq_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q  <= 1'b0;
      rcnt_q <= '0;
    end else if (evt_rst) begin
      rst_q  <= 1'b1;
      rcnt_q <= RCNT_LOAD;
    end else if (rcnt_q != '0) begin
      rcnt_q <= rcnt_q - RCNT_W'(1);
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign irq_req = irq_q;
  assign rst_req = rst_q;

  // R6: a pending request survives until acknowledged
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_ack) |=> irq_q);
  // R7: the pulse starts on the edge after a reset-mode crossing
  a_r7_pulse_start: assert property (@(posedge clk) disable iff (rst)
    evt_rst |=> rst_q);
  // R7: the pulse ends only when the down-counter has run out
  a_r7_pulse_end: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_q) |-> ($past(rcnt_q) == '0));

endmodule

// File: rtl/vmon_event_ctrl.sv
module vmon_event_ctrl
  import vmon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 4,
  parameter int RST_CYC     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_en,
  input  logic              cmp_hi,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic              rst_req
);

  logic       lvl_s;
  logic       filt_chg;
  logic       raw_rise;
  logic       raw_fall;
  logic       gate;
  logic       edge_sel;
  logic       evt;
  logic       flag;
  vmon_ctrl_t ctrl;

  vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_hi),
    .q   (lvl_s)
  );

  vmon_filter #(.FILT_N(FILT_N)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .lvl_in   (lvl_s),
    .filt_chg (filt_chg),
    .raw_rise (raw_rise),
    .raw_fall (raw_fall)
  );

  assign gate     = ctrl.det_en & ctrl.mon_en;
  assign edge_sel = ctrl.dir_fall ? raw_fall : raw_rise;
  assign evt      = gate & (ctrl.filt_off ? edge_sel : filt_chg);

  vmon_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .lvl   (lvl_s),
    .evt   (evt),
    .ctrl  (ctrl),
    .flag  (flag)
  );

  vmon_out #(.RST_CYC(RST_CYC)) u_out (
    .clk     (clk),
    .rst     (rst),
    .evt_irq (evt & ~ctrl.mode_rst),
    .evt_rst (evt & ctrl.mode_rst),
    .irq_ack (irq_ack),
    .irq_req (irq_req),
    .rst_req (rst_req)
  );

  // R1: with either enable low, nothing new is raised
  a_r1_gated: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (!$rose(irq_req) && !$rose(rst_req) && !$rose(flag)));
  // R7: a reset-mode crossing never raises the interrupt request
  a_r7_no_irq: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode_rst && !irq_req) |=> !irq_req);

endmodule

// File: tb/sim_vmon_event_ctrl.sv
`timescale 1ns/1ps
module sim_vmon_event_ctrl;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          samp_en = 1'b0;
  logic          cmp_hi = 1'b0;
  logic          reg_we = 1'b0;
  logic [0:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_ack = 1'b0;
  logic          irq_req;
  logic          rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vmon_event_ctrl u0 (
    .clk(clk), .rst(rst), .samp_en(samp_en), .cmp_hi(cmp_hi),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req),
    .rst_req(rst_req)
  );

  // strobe generator: one pulse every 4 clocks
  int sc = 0;
  always @(negedge clk) begin
    sc = (sc + 1) % 4;
    samp_en <= (sc == 0);
  end

  // behavioural reference
  int m_q[$];
  int m_prev, m_last, m_run, m_stable, m_flag, m_irq, m_rst, m_left;
  int m_ctrl, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_q = '{0, 0};
      m_prev = 0; m_last = 0; m_run = 0; m_stable = 0;
      m_flag = 0; m_irq = 0; m_rst = 0; m_left = 0; m_ctrl = 0; m_rd = 0;
    end else begin
      int lv, ev, on, chg, clr;
      lv  = m_q[1];
      on  = (m_ctrl & 3) == 3;
      chg = samp_en && lv == m_last && m_run == 3 && lv != m_stable;
      if (m_ctrl & 4)
        ev = on && ((m_ctrl & 8) ? (!lv && m_prev) : (lv && !m_prev));
      else
        ev = on && chg;
      if (reg_addr == 0) m_rd = m_ctrl;
      else               m_rd = (lv << 1) | m_flag;
      if (samp_en) begin
        if (lv != m_last) begin m_last = lv; m_run = 1; end
        else if (m_run < 4) begin
          m_run++;
          if (m_run == 4) m_stable = lv;
        end
      end
      m_prev = lv;
      void'(m_q.pop_back());
      m_q.push_front(int'(cmp_hi));
      clr = reg_we && reg_addr == 1 && !reg_wdata[0];
      if (ev) m_flag = 1; else if (clr) m_flag = 0;
      if (ev && !(m_ctrl & 16)) m_irq = 1; else if (irq_ack) m_irq = 0;
      if (ev && (m_ctrl & 16)) begin m_rst = 1; m_left = 7; end
      else if (m_left > 0) m_left--;
      else m_rst = 0;
      if (reg_we && reg_addr == 0) m_ctrl = int'(reg_wdata[4:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_req == m_irq[0], "R6 irq_req vs model", int'(irq_req), m_irq);
      chk(rst_req == m_rst[0], "R7 rst_req vs model", int'(rst_req), m_rst);
      chk(int'(reg_rdata) == m_rd, "R11 reg_rdata vs model", int'(reg_rdata), m_rd);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 1'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, n;
    tick(5);
    rst = 1'b0;
    tick(1);
    // R10: reset state
    chk(irq_req == 0, "R10 irq_req after reset", int'(irq_req), 0);
    chk(rst_req == 0, "R10 rst_req after reset", int'(rst_req), 0);
    rd(0, v); chk(v == 0, "R10 control word after reset", v, 0);
    rd(1, v); chk(v == 0, "R10 flag after reset", v, 0);

    // R9: level seen through the synchroniser
    @(negedge clk); cmp_hi = 1'b1;
    tick(3);
    rd(1, v); chk(v == 2, "R9 status level high", v, 2);
    @(negedge clk); cmp_hi = 1'b0;
    tick(3);
    rd(1, v); chk(v == 0, "R9 status level low", v, 0);
    tick(30);

    // R1: only one enable set, nothing happens
    wr(0, 'h01);
    @(negedge clk); cmp_hi = 1'b1; tick(40);
    @(negedge clk); cmp_hi = 1'b0; tick(40);
    wr(0, 'h06);
    @(negedge clk); cmp_hi = 1'b1; tick(10);
    @(negedge clk); cmp_hi = 1'b0; tick(10);
    chk(irq_req == 0, "R1 no irq while gated", int'(irq_req), 0);
    rd(1, v); chk(v == 0, "R1 no flag while gated", v, 0);
    rd(0, v); chk(v == 6, "R11 control readback", v, 6);

    // R2: filter active, short pulse is rejected
    wr(0, 'h03);
    tick(20);
    @(negedge clk); cmp_hi = 1'b1; tick(9);
    @(negedge clk); cmp_hi = 1'b0; tick(40);
    chk(irq_req == 0, "R2 short run rejected", int'(irq_req), 0);
    @(negedge clk); cmp_hi = 1'b1; tick(40);
    chk(irq_req == 1, "R2 long run accepted", int'(irq_req), 1);

    // R6 / R8: acknowledge and flag handling
    ack();
    chk(irq_req == 0, "R6 ack clears request", int'(irq_req), 0);
    rd(1, v); chk(v == 3, "R8 flag set with level", v, 3);
    wr(1, 'h01);
    rd(1, v); chk(v == 3, "R8 writing 1 keeps flag", v, 3);
    wr(1, 'h00);
    rd(1, v); chk(v == 2, "R8 writing 0 clears flag", v, 2);

    // R5: falling change with direction bit 0, and rising with bit 1
    @(negedge clk); cmp_hi = 1'b0; tick(40);
    chk(irq_req == 1, "R5 falling change filtered", int'(irq_req), 1);
    ack();
    wr(0, 'h0B);
    @(negedge clk); cmp_hi = 1'b1; tick(40);
    chk(irq_req == 1, "R5 rising change with dir bit 1", int'(irq_req), 1);
    ack();
    @(negedge clk); cmp_hi = 1'b0; tick(40);
    ack();
    wr(1, 'h00);

    // R3: bypass latency
    wr(0, 'h07);
    tick(4);
    @(negedge clk); cmp_hi = 1'b1;
    tick(2);
    chk(irq_req == 0, "R3 not yet after two edges", int'(irq_req), 0);
    tick(1);
    chk(irq_req == 1, "R3 seen after third edge", int'(irq_req), 1);
    ack();

    // R4: direction select in bypass
    @(negedge clk); cmp_hi = 1'b0; tick(10);
    chk(irq_req == 0, "R4 falling ignored with dir 0", int'(irq_req), 0);
    wr(0, 'h0F);
    @(negedge clk); cmp_hi = 1'b1; tick(10);
    chk(irq_req == 0, "R4 rising ignored with dir 1", int'(irq_req), 0);
    @(negedge clk); cmp_hi = 1'b0; tick(4);
    chk(irq_req == 1, "R4 falling taken with dir 1", int'(irq_req), 1);
    ack();
    wr(1, 'h00);

    // R6 / R8: crossing on the same edge as ack and clearing write
    wr(0, 'h07);
    tick(4);
    @(negedge clk); cmp_hi = 1'b1;
    tick(2);
    reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = '0; irq_ack = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; irq_ack = 1'b0;
    chk(irq_req == 1, "R6 set beats ack", int'(irq_req), 1);
    rd(1, v); chk(v == 3, "R8 set beats clear", v, 3);
    ack();
    wr(1, 'h00);
    @(negedge clk); cmp_hi = 1'b0; tick(6);

    // R7: reset mode pulse
    wr(0, 'h17);
    tick(4);
    @(negedge clk); cmp_hi = 1'b1;
    tick(3);
    n = 0;
    while (rst_req && n < 40) begin n++; @(negedge clk); end
    chk(n == 8, "R7 pulse length", n, 8);
    chk(irq_req == 0, "R7 no irq in reset mode", int'(irq_req), 0);
    rd(0, v); chk(v == 'h17, "R7 control kept", v, 'h17);
    rd(1, v); chk(v == 3, "R8 flag set in reset mode", v, 3);

    tick(5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule